// File: doc/BRIEF.md
# Timestamp Latency Calibration Sequencer

This block is a small bus master that loads the transmit and receive path-delay values used by a 10G Ethernet MAC's timestamping logic. Once the link has come up and stayed up for a programmable number of cycles, it reads the PHY's measure-valid register repeatedly until both the TX and RX flags are set. It then reads the raw deterministic-latency values for both directions and turns each one into a 32-bit 16.16 fixed-point nanosecond value by shifting it left sixteen places. It adds the configured PMA delay for that direction and writes the fraction half and the nanosecond half of each result into the MAC.

A mode input selects one of two PHY register layouts: USXGMII, with one 16-bit register for each latency, or multi-gig, where each latency is built from two byte registers. The calibration runs once for each link-up period. A drop of `link_up` at any point abandons the sequence, clears the status outputs and sends the machine back to wait for a stable link.

The states are S_WAIT (qualifying the link), S_POLL (reading the valid flags), S_RD_TX0, S_RD_TX1, S_RD_RX0 and S_RD_RX1 (latency reads), S_WR_TXF, S_WR_TXN, S_WR_RXF and S_WR_RXN (MAC writes), and S_DONE. The transitions are as follows. S_WAIT goes to S_POLL when the link is stable. S_POLL goes to S_RD_TX0 on an accepted read with bits 1:0 equal to 11. S_RD_TX0 goes to S_RD_RX0 in USXGMII mode and to S_RD_TX1 in multi-gig mode. S_RD_TX1 goes to S_RD_RX0. S_RD_RX0 goes to S_WR_TXF in USXGMII mode and to S_RD_RX1 in multi-gig mode. S_RD_RX1 goes to S_WR_TXF. Each write state goes to the next write state when its access is accepted, and S_WR_RXN goes to S_DONE. Every state goes to S_WAIT whenever `link_up` is low.

Top module: `tscal_seq`

## Requirements
- R1: While reset is asserted, `phy_read`, `mac_write`, `cal_done` and `cal_err` are all 0.
- R2: No bus access is made until `link_up` has been high for `stable_cycles` consecutive clock edges.
- R3: The block reads the valid register repeatedly until an accepted read returns 1 in both bit 0 (TX valid) and bit 1 (RX valid). The valid register is at PHY address 0x420 when `usx_mode`=1 and at 0x017 when `usx_mode`=0. A read that has only one of the two bits set causes another read.
- R4: When `usx_mode`=1, the TX latency is read as all 16 bits of PHY address 0x421, and then the RX latency as all 16 bits of 0x422.
- R5: When `usx_mode`=0, the reads come in this order: 0x018 (TX low byte), 0x019 (TX high byte), 0x01B (RX low byte), 0x01A (RX high byte). Only bits 7:0 of each read are used.
- R6: For each direction, the value written equals raw × 65536 + the PMA delay, taken as a 32-bit unsigned sum. The fraction half is bits 15:0 and the nanosecond half is bits 31:16.
- R7: When `usx_mode`=1, the writes go in order to MAC address 0x102 (TX fraction), 0x104 (TX ns), 0x122 (RX fraction) and 0x124 (RX ns).
- R8: When `usx_mode`=0, the writes go in order to MAC address 0x10A (TX fraction), 0x10C (TX ns), 0x12A (RX fraction) and 0x12C (RX ns).
- R9: While `*_waitreq` is high, a pending read or write keeps its strobe, address and write data unchanged.
- R10: `cal_done` rises after the last write is accepted and no further access follows while the link stays up. `cal_done` is cleared one edge after `link_up` goes low.
- R11: A drop of `link_up` during the sequence abandons it. A full sequence, starting again with polling, runs once the link is stable again.
- R12: If a sum exceeds 32 bits, both halves written for that direction are 0xFFFF and `cal_err` is set. `cal_err` is cleared when `link_up` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link status from the PHY |
| stable_cycles | input | CNT_W | Number of cycles the link must stay up to count as stable |
| usx_mode | input | 1 | 1 selects the USXGMII register layout, 0 the multi-gig layout |
| tx_pma_delay | input | 2*DW | TX PMA delay, 16.16 ns |
| rx_pma_delay | input | 2*DW | RX PMA delay, 16.16 ns |
| phy_read | output | 1 | PHY read strobe |
| phy_addr | output | PHY_AW | PHY register address |
| phy_rdata | input | DW | PHY read data, valid when the read is accepted |
| phy_waitreq | input | 1 | PHY stall |
| mac_write | output | 1 | MAC write strobe |
| mac_addr | output | MAC_AW | MAC register address |
| mac_wdata | output | DW | MAC write data |
| mac_waitreq | input | 1 | MAC stall |
| cal_done | output | 1 | Calibration complete for this link-up period |
| cal_err | output | 1 | A latency sum saturated |

## Verification
The first access can appear no earlier than `stable_cycles`+1 edges after `link_up` rises, because the stability counter and then the state register each take one edge. After that, every state advances on the edge where its strobe is high and the waitrequest is low. The bench's scoreboard monitor therefore samples each access at the falling edge before the edge that accepts it. It compares the access against the queue the driver filled in the order the requirements give, and marks any access made during a required-quiet window as a failure. `cal_done` and `cal_err` are checked two edges after a link drop, which is one edge past when they must clear. Their completion values are checked only after polling for `cal_done`.

// File: rtl/tscal_pkg.sv
package tscal_pkg;

    typedef enum logic [3:0] {
        S_WAIT, S_POLL,
        S_RD_TX0, S_RD_TX1, S_RD_RX0, S_RD_RX1,
        S_WR_TXF, S_WR_TXN, S_WR_RXF, S_WR_RXN,
        S_DONE
    } cal_state_e;

    // PHY register addresses, USXGMII layout
    localparam logic [11:0] USX_VALID  = 12'h420;
    localparam logic [11:0] USX_TX_LAT = 12'h421;
    localparam logic [11:0] USX_RX_LAT = 12'h422;
    // PHY register addresses, multi-gig layout
    localparam logic [11:0] MG_VALID   = 12'h017;
    localparam logic [11:0] MG_TX_LO   = 12'h018;
    localparam logic [11:0] MG_TX_HI   = 12'h019;
    localparam logic [11:0] MG_RX_LO   = 12'h01B;
    localparam logic [11:0] MG_RX_HI   = 12'h01A;
    // MAC path-delay registers
    localparam logic [11:0] USX_TXF    = 12'h102;
    localparam logic [11:0] USX_TXN    = 12'h104;
    localparam logic [11:0] USX_RXF    = 12'h122;
    localparam logic [11:0] USX_RXN    = 12'h124;
    localparam logic [11:0] MG_TXF     = 12'h10A;
    localparam logic [11:0] MG_TXN     = 12'h10C;
    localparam logic [11:0] MG_RXF     = 12'h12A;
    localparam logic [11:0] MG_RXN     = 12'h12C;

endpackage

// File: rtl/link_qual.sv
module link_qual #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic [CNT_W-1:0] limit,
    output logic             stable
);
    logic [CNT_W-1:0] cnt_q;

    // Counts consecutive edges with the link up, and stops at full scale
    always_ff @(posedge clk) begin
        if (!rst_n || !link_up) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stable = link_up && (cnt_q >= limit);
endmodule

// File: rtl/lat_calc.sv
module lat_calc #(
    parameter int RAW_W = 16,
    parameter int FIX_W = 32
) (
    input  logic [RAW_W-1:0] raw,
    input  logic [FIX_W-1:0] pma,
    output logic [FIX_W-1:0] fixed,
    output logic             ovf
);
    localparam int FRAC_W = FIX_W - RAW_W;

    logic [FIX_W:0] sum;

    always_comb begin
        sum   = {1'b0, raw, {FRAC_W{1'b0}}} + {1'b0, pma};
        ovf   = sum[FIX_W];
        fixed = ovf ? '1 : sum[FIX_W-1:0];
    end
endmodule

// File: rtl/tscal_seq.sv
module tscal_seq
    import tscal_pkg::*;
#(
    parameter int PHY_AW = 12,
    parameter int MAC_AW = 12,
    parameter int DW     = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic [CNT_W-1:0]  stable_cycles,
    input  logic              usx_mode,
    input  logic [2*DW-1:0]   tx_pma_delay,
    input  logic [2*DW-1:0]   rx_pma_delay,
    output logic              phy_read,
    output logic [PHY_AW-1:0] phy_addr,
    input  logic [DW-1:0]     phy_rdata,
    input  logic              phy_waitreq,
    output logic              mac_write,
    output logic [MAC_AW-1:0] mac_addr,
    output logic [DW-1:0]     mac_wdata,
    input  logic              mac_waitreq,
    output logic              cal_done,
    output logic              cal_err
);
    localparam int FIX_W = 2 * DW;
    localparam int HB    = DW / 2;
    localparam int NDIR  = 2;

    cal_state_e        state_q, state_d;
    logic              mode_q;
    logic              stable;
    logic              phy_acc, mac_acc;
    logic              both_valid;
    logic              err_q;
    logic [DW-1:0]     raw_q [NDIR];
    logic [FIX_W-1:0]  fix_w [NDIR];
    logic              ovf_w [NDIR];

    link_qual #(.CNT_W(CNT_W)) u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .link_up(link_up),
        .limit  (stable_cycles),
        .stable (stable)
    );

    // One converter per direction: index 0 is TX, index 1 is RX
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        lat_calc #(.RAW_W(DW), .FIX_W(FIX_W)) u_calc (
            .raw  (raw_q[d]),
            .pma  ((d == 0) ? tx_pma_delay : rx_pma_delay),
            .fixed(fix_w[d]),
            .ovf  (ovf_w[d])
        );
    end

    assign phy_acc    = phy_read && !phy_waitreq;
    assign mac_acc    = mac_write && !mac_waitreq;
    assign both_valid = phy_rdata[0] && phy_rdata[1];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT:   if (stable) state_d = S_POLL;
            S_POLL:   if (phy_acc && both_valid) state_d = S_RD_TX0;
            S_RD_TX0: if (phy_acc) state_d = mode_q ? S_RD_RX0 : S_RD_TX1;
            S_RD_TX1: if (phy_acc) state_d = S_RD_RX0;
            S_RD_RX0: if (phy_acc) state_d = mode_q ? S_WR_TXF : S_RD_RX1;
            S_RD_RX1: if (phy_acc) state_d = S_WR_TXF;
            S_WR_TXF: if (mac_acc) state_d = S_WR_TXN;
            S_WR_TXN: if (mac_acc) state_d = S_WR_RXF;
            S_WR_RXF: if (mac_acc) state_d = S_WR_RXN;
            S_WR_RXN: if (mac_acc) state_d = S_DONE;
            S_DONE:   state_d = S_DONE;
            default:  state_d = S_WAIT;
        endcase
        if (!link_up) state_d = S_WAIT;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // The mode is sampled while waiting and held for the whole sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (state_q == S_WAIT) begin
            mode_q <= usx_mode;
        end
    end

    // Capture of the raw latencies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q[0] <= '0;
            raw_q[1] <= '0;
        end else if (phy_acc) begin
            case (state_q)
                S_RD_TX0: if (mode_q) raw_q[0] <= phy_rdata;
                          else        raw_q[0][HB-1:0] <= phy_rdata[HB-1:0];
                S_RD_TX1: raw_q[0][DW-1:HB] <= phy_rdata[HB-1:0];
                S_RD_RX0: if (mode_q) raw_q[1] <= phy_rdata;
                          else        raw_q[1][HB-1:0] <= phy_rdata[HB-1:0];
                S_RD_RX1: raw_q[1][DW-1:HB] <= phy_rdata[HB-1:0];
                default: ;
            endcase
        end
    end

    // Sticky saturation flag, cleared while the link is down
    always_ff @(posedge clk) begin
        if (!rst_n || !link_up) begin
            err_q <= 1'b0;
        end else if (state_q == S_WR_TXF && (ovf_w[0] || ovf_w[1])) begin
            err_q <= 1'b1;
        end
    end

    // Output decode
    always_comb begin
        phy_read  = 1'b0;
        phy_addr  = '0;
        mac_write = 1'b0;
        mac_addr  = '0;
        mac_wdata = '0;
        unique case (state_q)
            S_WAIT, S_DONE: ;
            S_POLL: begin
                phy_read = 1'b1;
                phy_addr = PHY_AW'(mode_q ? USX_VALID : MG_VALID);
            end
            S_RD_TX0: begin
                phy_read = 1'b1;
                phy_addr = PHY_AW'(mode_q ? USX_TX_LAT : MG_TX_LO);
            end
            S_RD_TX1: begin
                phy_read = 1'b1;
                phy_addr = PHY_AW'(MG_TX_HI);
            end
            S_RD_RX0: begin
                phy_read = 1'b1;
                phy_addr = PHY_AW'(mode_q ? USX_RX_LAT : MG_RX_LO);
            end
            S_RD_RX1: begin
                phy_read = 1'b1;
                phy_addr = PHY_AW'(MG_RX_HI);
            end
            S_WR_TXF: begin
                mac_write = 1'b1;
                mac_addr  = MAC_AW'(mode_q ? USX_TXF : MG_TXF);
                mac_wdata = fix_w[0][DW-1:0];
            end
            S_WR_TXN: begin
                mac_write = 1'b1;
                mac_addr  = MAC_AW'(mode_q ? USX_TXN : MG_TXN);
                mac_wdata = fix_w[0][FIX_W-1:DW];
            end
            S_WR_RXF: begin
                mac_write = 1'b1;
                mac_addr  = MAC_AW'(mode_q ? USX_RXF : MG_RXF);
                mac_wdata = fix_w[1][DW-1:0];
            end
            S_WR_RXN: begin
                mac_write = 1'b1;
                mac_addr  = MAC_AW'(mode_q ? USX_RXN : MG_RXN);
                mac_wdata = fix_w[1][FIX_W-1:DW];
            end
            default: ;
        endcase
    end

    assign cal_done = (state_q == S_DONE);
    assign cal_err  = err_q;

    // R9: a stalled read keeps its strobe and address
    a_r9_phy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_read && phy_waitreq && link_up) |=> (phy_read && $stable(phy_addr)));

    // R9: a stalled write keeps its strobe, address and data
    a_r9_mac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_write && mac_waitreq && link_up) |=>
            (mac_write && $stable(mac_addr) && $stable(mac_wdata)));

    // R10, R12: status clears one edge after the link is lost
    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (!cal_done && !cal_err));

    // R2: an access needs the link to have been up at the previous edge
    a_r2_access_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_read || mac_write) |-> $past(link_up));

    // R9: the two masters never drive at the same time
    a_r9_one_master: assert property (@(posedge clk) disable iff (!rst_n)
        !(phy_read && mac_write));

    // R10: done only appears after the final write was accepted
    a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> $past(mac_write && !mac_waitreq));
endmodule

// File: tb/tb_tscal_seq.sv
module tb_tscal_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [15:0] data;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic        usx_mode = 1'b1;
    logic [31:0] tx_pma = '0, rx_pma = '0;
    logic        phy_read, mac_write, cal_done, cal_err;
    logic [11:0] phy_addr, mac_addr;
    logic [15:0] phy_rdata, mac_wdata;
    logic        phy_waitreq, mac_waitreq;
    logic [7:0]  lfsr;
    logic        wait_en = 1'b0;
    logic [15:0] m_tx = '0, m_rx = '0;
    int          poll_cnt, poll_need = 0;
    bit          quiet = 1'b0, ignore = 1'b0;
    acc_t        exp_q[$];
    int          mon_checks = 0, mon_fails = 0;
    int          drv_checks = 0, drv_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tscal_seq dut (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .stable_cycles(16'(LIMIT)), .usx_mode(usx_mode),
        .tx_pma_delay(tx_pma), .rx_pma_delay(rx_pma),
        .phy_read(phy_read), .phy_addr(phy_addr), .phy_rdata(phy_rdata),
        .phy_waitreq(phy_waitreq), .mac_write(mac_write), .mac_addr(mac_addr),
        .mac_wdata(mac_wdata), .mac_waitreq(mac_waitreq),
        .cal_done(cal_done), .cal_err(cal_err)
    );

    // Slave models with pseudo-random stalls
    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr     <= 8'h5A;
            poll_cnt <= 0;
        end else begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (phy_read && !phy_waitreq && (phy_addr == 12'h420 || phy_addr == 12'h017))
                poll_cnt <= poll_cnt + 1;
        end
    end
    assign phy_waitreq = wait_en & lfsr[0];
    assign mac_waitreq = wait_en & lfsr[1];

    always_comb begin
        case (phy_addr)
            12'h420, 12'h017: phy_rdata = (poll_cnt >= poll_need) ? 16'h0003 : 16'h0001;
            12'h421: phy_rdata = m_tx;
            12'h422: phy_rdata = m_rx;
            12'h018: phy_rdata = {8'hA5, m_tx[7:0]};
            12'h019: phy_rdata = {8'h5A, m_tx[15:8]};
            12'h01B: phy_rdata = {8'hC3, m_rx[7:0]};
            12'h01A: phy_rdata = {8'h3C, m_rx[15:8]};
            default: phy_rdata = 16'hDEAD;
        endcase
    end

    // Monitor: pops and compares each accepted access
    always @(negedge clk) begin
        if (rst_n && !ignore) begin
            if (quiet && (phy_read || mac_write)) begin
                mon_checks++; mon_fails++;
                $display("FAIL R2/R10: access during quiet window, got addr %h expected none", phy_read ? phy_addr : mac_addr);
            end
            if ((phy_read && !phy_waitreq) || (mac_write && !mac_waitreq)) begin
                acc_t got, e;
                got.wr   = mac_write;
                got.addr = mac_write ? mac_addr : phy_addr;
                got.data = mac_write ? mac_wdata : 16'h0;
                mon_checks++;
                if (exp_q.size() == 0) begin
                    mon_fails++;
                    $display("FAIL R3-R8 order: unexpected access got %h expected none", got);
                end else begin
                    e = exp_q.pop_front();
                    if (got != e) begin
                        mon_fails++;
                        $display("FAIL R3/R4/R5/R6/R7/R8: access got wr=%0b addr=%h data=%h expected wr=%0b addr=%h data=%h",
                                 got.wr, got.addr, got.data, e.wr, e.addr, e.data);
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        drv_checks++;
        if (act !== exp) begin
            drv_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] fixsum(input logic [15:0] raw, input logic [31:0] pma);
        logic [32:0] s;
        s = {1'b0, raw, 16'h0} + {1'b0, pma};
        if (s[32]) return {1'b1, 32'hFFFF_FFFF};
        return s;
    endfunction

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // Driver: loads the models and queues the expected accesses
    task automatic start_cal(input bit usx, input logic [15:0] txr, input logic [15:0] rxr,
                             input logic [31:0] tp, input logic [31:0] rp, input int fails);
        logic [32:0] ts, rs;
        usx_mode = usx; m_tx = txr; m_rx = rxr; tx_pma = tp; rx_pma = rp;
        poll_need = poll_cnt + fails;
        ts = fixsum(txr, tp); rs = fixsum(rxr, rp);
        for (int i = 0; i <= fails; i++) exp_q.push_back({1'b0, usx ? 12'h420 : 12'h017, 16'h0});
        if (usx) begin
            exp_q.push_back({1'b0, 12'h421, 16'h0});
            exp_q.push_back({1'b0, 12'h422, 16'h0});
        end else begin
            exp_q.push_back({1'b0, 12'h018, 16'h0});
            exp_q.push_back({1'b0, 12'h019, 16'h0});
            exp_q.push_back({1'b0, 12'h01B, 16'h0});
            exp_q.push_back({1'b0, 12'h01A, 16'h0});
        end
        exp_q.push_back({1'b1, usx ? 12'h102 : 12'h10A, ts[15:0]});
        exp_q.push_back({1'b1, usx ? 12'h104 : 12'h10C, ts[31:16]});
        exp_q.push_back({1'b1, usx ? 12'h122 : 12'h12A, rs[15:0]});
        exp_q.push_back({1'b1, usx ? 12'h124 : 12'h12C, rs[31:16]});
        // R2: quiet while the link qualifies
        quiet = 1'b1; link_up = 1'b1;
        cyc(LIMIT);
        quiet = 1'b0;
    endtask

    task automatic finish_cal(input bit exp_err);
        int n = 0;
        while (!cal_done && n < 3000) begin cyc(1); n++; end
        chk("R10 done after last write", 32'(cal_done), 32'd1);
        chk("R10 all accesses seen", 32'(exp_q.size()), 32'd0);
        chk("R12 error flag", 32'(cal_err), 32'(exp_err));
        quiet = 1'b1; cyc(40); quiet = 1'b0;      // R10: runs only once
        chk("R10 done held", 32'(cal_done), 32'd1);
        link_up = 1'b0; cyc(2);
        chk("R10 done clears on link loss", 32'(cal_done), 32'd0);
        chk("R12 error clears on link loss", 32'(cal_err), 32'd0);
        cyc(3);
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            begin
                cyc(3);
                // R1: idle during reset
                chk("R1 read idle", 32'(phy_read), 32'd0);
                chk("R1 write idle", 32'(mac_write), 32'd0);
                chk("R1 done low", 32'(cal_done), 32'd0);
                chk("R1 err low", 32'(cal_err), 32'd0);
                rst_n = 1'b1; cyc(3);

                // R3 R4 R6 R7: USXGMII, partial valid polls, no stalls
                start_cal(1'b1, 16'h0123, 16'h0456, 32'h0002_8000, 32'h0001_4000, 3);
                finish_cal(1'b0);

                // R5 R8 R9: multi-gig with stalls
                wait_en = 1'b1;
                start_cal(1'b0, 16'h1234, 16'h5678, 32'h0000_C000, 32'h0003_0001, 2);
                finish_cal(1'b0);

                // R11: abort mid-sequence, then full rerun
                start_cal(1'b0, 16'h00FF, 16'hFF00, 32'h0, 32'h0000_0001, 1);
                wait (exp_q.size() <= 5);
                @(posedge clk); #1;
                ignore = 1'b1; link_up = 1'b0;
                cyc(2);
                chk("R11 done low after abort", 32'(cal_done), 32'd0);
                exp_q.delete();
                ignore = 1'b0; quiet = 1'b1; cyc(10); quiet = 1'b0;
                start_cal(1'b0, 16'h00FF, 16'hFF00, 32'h0, 32'h0000_0001, 0);
                finish_cal(1'b0);

                // R12 R6: saturation on TX, normal RX
                start_cal(1'b1, 16'hFFFF, 16'h0010, 32'h0001_0000, 32'h0000_0010, 0);
                finish_cal(1'b1);
            end
            begin
                cyc(100000);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            drv_checks++; drv_fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==",
                 drv_checks + mon_checks, drv_fails + mon_fails);
        $finish;
    end
endmodule